// File: doc/BRIEF.md
# Video and Sliced-Text Output Serializer

This block drives a byte-wide or halfword-wide video output port from two upstream buffers. One buffer holds packed video samples and the other holds sliced vertical-blanking text. Both are 32-bit-word show-ahead FIFOs. At each packet boundary a small arbiter chooses the source, using a 2-bit policy code, the blanking state and each buffer's "filled" flag. The block then emits one packet and does not interrupt it.

A video packet is a start-of-active-video timing code, a configured number of payload words, and an end-of-active-video code. A text packet is framed in one of two ways, chosen by configuration: by the same timing-code pair with the vertical-blanking bit set, or by an ancillary header with no trailer.

Payload bytes are clipped so that they never look like a timing preamble. Every cycle carries a data-valid flag. Any cycle that is not valid drives zero on both byte lanes.

Top module: `oport_ser`

## Requirements
- R1: While `rst_ni` is low, `dv_o`, `dat_o`, `vid_rd_o` and `txt_rd_o` are all zero.
- R2: In 8-bit mode (`mode16_i`=0), each payload word goes out over four valid cycles on `dat_o[7:0]`, in the order bits [7:0], [15:8], [23:16], [31:24], and `dat_o[15:8]` stays 00H. In 16-bit mode, each word takes two valid cycles: first [7:0] on the lower lane with [15:8] on the upper lane, then [23:16] on the lower lane with [31:24] on the upper lane.
- R3: A timing code is the four bytes FFH, 00H, 00H, XY. The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with H=0 for the start code and H=1 for the end code. A video packet is a start code with V=0, then `vid_dw_i` payload words, then an end code with V=0.
- R4: When `txt_anc_i`=1, a text packet is 00H, FFH, FFH, `anc_did_i`, `anc_blk_i`, the word count `txt_dw_i`, then `txt_dw_i` payload words, with no trailer. When `txt_anc_i`=0, a text packet uses start and end codes with V=1 around its payload.
- R5: In 16-bit mode, header and trailer bytes are paired: byte 2k goes on the lower lane and byte 2k+1 on the upper lane of the same cycle.
- R6: Any cycle with `dv_o`=0 drives `dat_o`=0000H. This includes a stall when the active FIFO is empty partway through a packet; the packet resumes when data arrives.
- R7: A payload byte of 00H is sent as 01H and a payload byte of FFH is sent as FEH. Header and trailer bytes are never altered.
- R8: The arbitration codes on `arb_i` are: 00 = video first, text when no video is ready; 01 = text only while `blank_i`=1 and no video is ready; 10 = text first; 11 = text never sent. A source is ready when its filled flag is high.
- R9: A packet that has started runs to its end regardless of newly ready sources. The F bit is taken from `field_i` when the packet starts.
- R10: Exactly one read strobe is issued per payload word, in the cycle that carries its last byte. A strobe is never issued to an empty FIFO, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode16_i | input | 1 | 1 selects 16-bit output |
| arb_i | input | 2 | Arbitration policy code |
| txt_anc_i | input | 1 | 1 frames text with the ancillary header |
| blank_i | input | 1 | Vertical blanking in progress |
| field_i | input | 1 | Field identifier for timing codes |
| anc_did_i | input | 8 | Ancillary data ID byte |
| anc_blk_i | input | 8 | Ancillary block count byte |
| vid_dw_i | input | 8 | Words per video line (1 or more) |
| txt_dw_i | input | 8 | Words per text packet (1 or more) |
| vid_data_i | input | 32 | Video FIFO head word |
| vid_empty_i | input | 1 | Video FIFO empty |
| vid_fill_i | input | 1 | Video FIFO at filled threshold |
| vid_rd_o | output | 1 | Video FIFO pop |
| txt_data_i | input | 32 | Text FIFO head word |
| txt_empty_i | input | 1 | Text FIFO empty |
| txt_fill_i | input | 1 | Text FIFO at filled threshold |
| txt_rd_o | output | 1 | Text FIFO pop |
| dat_o | output | 16 | Output data, lower lane [7:0] |
| dv_o | output | 1 | Output data valid |

## Verification
Two situations can coincide. The first is a new source becoming ready while a packet is being sent. The second is `field_i` changing during that same packet. The bench provokes this by loading the text FIFO and toggling the field a few cycles after a video header has started, with the text-priority policy selected. It then requires the captured byte stream to show the complete video packet with the old F bit, followed by the text packet with the new F bit. A further sweep covers every policy code, blanking level, bus width and text framing; in each case the valid-byte stream is compared against a stream built independently in the bench.

// File: rtl/oport_pkg.sv
package oport_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_TRL} st_e;
  typedef enum logic [1:0] {ARB_VID = 2'b00, ARB_BLANK = 2'b01,
                            ARB_TXT = 2'b10, ARB_NOTXT = 2'b11} arb_e;

  function automatic logic [7:0] xy_code(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // keep payload out of the preamble values
  function automatic logic [7:0] clip(input logic [7:0] b);
    if (b == 8'h00) return 8'h01;
    if (b == 8'hFF) return 8'hFE;
    return b;
  endfunction
endpackage

// File: rtl/oport_arb.sv
module oport_arb
  import oport_pkg::*;
(
  input  logic [1:0] arb_i,
  input  logic       blank_i,
  input  logic       vreq_i,
  input  logic       treq_i,
  output logic       go_o,
  output logic       pick_txt_o
);
  always_comb begin
    unique case (arb_i)
      ARB_VID:   pick_txt_o = !vreq_i && treq_i;
      ARB_BLANK: pick_txt_o = !vreq_i && treq_i && blank_i;
      ARB_TXT:   pick_txt_o = treq_i;
      default:   pick_txt_o = 1'b0;
    endcase
    go_o = vreq_i || pick_txt_o;
  end
endmodule

// File: rtl/oport_code.sv
module oport_code
  import oport_pkg::*;
(
  input  logic       anc_i,
  input  logic       f_i,
  input  logic       v_i,
  input  logic       eav_i,
  input  logic [2:0] idx_i,
  input  logic [7:0] did_i,
  input  logic [7:0] blk_i,
  input  logic [7:0] cnt_i,
  output logic [7:0] byte_o
);
  always_comb begin
    if (anc_i) begin
      unique case (idx_i)
        3'd0:    byte_o = 8'h00;
        3'd1,
        3'd2:    byte_o = 8'hFF;
        3'd3:    byte_o = did_i;
        3'd4:    byte_o = blk_i;
        default: byte_o = cnt_i;
      endcase
    end else begin
      unique case (idx_i[1:0])
        2'd0:    byte_o = 8'hFF;
        2'd3:    byte_o = xy_code(f_i, v_i, eav_i);
        default: byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/oport_lane.sv
module oport_lane
  import oport_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int BPW   = WORD_W / 8,
  localparam int POS_W = $clog2(BPW)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic [7:0]        lo_o,
  output logic [7:0]        hi_o
);
  logic [POS_W-1:0] pos1;
  assign pos1 = pos_i + POS_W'(1);
  assign lo_o = clip(word_i[8*pos_i +: 8]);
  assign hi_o = clip(word_i[8*pos1 +: 8]);
endmodule

// File: rtl/oport_ser.sv
module oport_ser
  import oport_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  localparam int BPW   = WORD_W / 8,
  localparam int POS_W = $clog2(BPW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode16_i,
  input  logic [1:0]        arb_i,
  input  logic              txt_anc_i,
  input  logic              blank_i,
  input  logic              field_i,
  input  logic [7:0]        anc_did_i,
  input  logic [7:0]        anc_blk_i,
  input  logic [CNT_W-1:0]  vid_dw_i,
  input  logic [CNT_W-1:0]  txt_dw_i,
  input  logic [WORD_W-1:0] vid_data_i,
  input  logic              vid_empty_i,
  input  logic              vid_fill_i,
  output logic              vid_rd_o,
  input  logic [WORD_W-1:0] txt_data_i,
  input  logic              txt_empty_i,
  input  logic              txt_fill_i,
  output logic              txt_rd_o,
  output logic [15:0]       dat_o,
  output logic              dv_o
);
  st_e              st_q;
  logic             src_q, anc_q, f_q, v_q;
  logic [CNT_W-1:0] cnt_q, dc_q;
  logic [2:0]       idx_q;
  logic [POS_W-1:0] pos_q;

  logic       go, pick_txt;
  logic [1:0] step;
  logic [3:0] idx_nx, hlen;
  logic [POS_W:0] pos_nx;
  logic       last_byte, cur_empty, emit, rd;
  logic [WORD_W-1:0] cur_word;
  logic [7:0] code_b [2];
  logic [7:0] pay_lo, pay_hi, lo_b, hi_b;

  oport_arb u_arb (
    .arb_i(arb_i), .blank_i(blank_i), .vreq_i(vid_fill_i), .treq_i(txt_fill_i),
    .go_o(go), .pick_txt_o(pick_txt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_code
    oport_code u_code (
      .anc_i(anc_q), .f_i(f_q), .v_i(v_q), .eav_i(st_q == ST_TRL),
      .idx_i(idx_q + 3'(g)), .did_i(anc_did_i), .blk_i(anc_blk_i),
      .cnt_i(8'(cnt_q)), .byte_o(code_b[g])
    );
  end

  assign cur_word  = src_q ? txt_data_i : vid_data_i;
  assign cur_empty = src_q ? txt_empty_i : vid_empty_i;

  oport_lane #(.WORD_W(WORD_W)) u_lane (
    .word_i(cur_word), .pos_i(pos_q), .lo_o(pay_lo), .hi_o(pay_hi)
  );

  assign step      = mode16_i ? 2'd2 : 2'd1;
  assign idx_nx    = {1'b0, idx_q} + {2'b00, step};
  assign hlen      = anc_q ? 4'd6 : 4'd4;
  assign pos_nx    = {1'b0, pos_q} + (POS_W+1)'(step);
  assign last_byte = pos_nx == (POS_W+1)'(BPW);

  always_comb begin
    emit = 1'b0;
    lo_b = 8'h00;
    hi_b = 8'h00;
    unique case (st_q)
      ST_HDR, ST_TRL: begin emit = 1'b1; lo_b = code_b[0]; hi_b = code_b[1]; end
      ST_PAY: if (!cur_empty) begin emit = 1'b1; lo_b = pay_lo; hi_b = pay_hi; end
      default: ;
    endcase
  end

  assign rd       = (st_q == ST_PAY) && emit && last_byte;
  assign vid_rd_o = rd && !src_q;
  assign txt_rd_o = rd && src_q;
  assign dv_o     = emit;
  assign dat_o    = emit ? {mode16_i ? hi_b : 8'h00, lo_b} : 16'h0000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      src_q <= 1'b0;
      anc_q <= 1'b0;
      f_q   <= 1'b0;
      v_q   <= 1'b0;
      cnt_q <= '0;
      dc_q  <= '0;
      idx_q <= '0;
      pos_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          src_q <= pick_txt;
          anc_q <= pick_txt && txt_anc_i;
          f_q   <= field_i;
          v_q   <= pick_txt;
          cnt_q <= pick_txt ? txt_dw_i : vid_dw_i;
          idx_q <= '0;
          st_q  <= ST_HDR;
        end
        ST_HDR: begin
          if (idx_nx >= hlen) begin
            st_q  <= ST_PAY;
            pos_q <= '0;
            dc_q  <= '0;
          end else idx_q <= idx_nx[2:0];
        end
        ST_PAY: if (emit) begin
          if (last_byte) begin
            pos_q <= '0;
            if (dc_q + CNT_W'(1) >= cnt_q) begin
              st_q  <= anc_q ? ST_IDLE : ST_TRL;
              idx_q <= '0;
            end else dc_q <= dc_q + CNT_W'(1);
          end else pos_q <= pos_nx[POS_W-1:0];
        end
        ST_TRL: begin
          if (idx_nx >= 4'd4) st_q <= ST_IDLE;
          else idx_q <= idx_nx[2:0];
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oport_ser_chk.sv
module oport_ser_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mode16_i,
  input logic        vid_empty_i,
  input logic        txt_empty_i,
  input logic        vid_rd_o,
  input logic        txt_rd_o,
  input logic [15:0] dat_o,
  input logic        dv_o
);
  // R6
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dv_o |-> dat_o == 16'h0000);
  // R2
  upper_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode16_i |-> dat_o[15:8] == 8'h00);
  // R10
  vid_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_rd_o |-> !vid_empty_i && dv_o);
  // R10
  txt_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txt_rd_o |-> !txt_empty_i && dv_o);
  // R10
  pop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vid_rd_o && txt_rd_o));
endmodule

bind oport_ser oport_ser_chk u_chk (.*);

// File: tb/oport_ser_bench.sv
module oport_ser_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        mode16 = 0, txt_anc = 0, blank = 0, field = 0;
  logic [1:0]  arb = 0;
  logic [7:0]  vid_dw = 8'd3, txt_dw = 8'd2;
  logic [31:0] vmem [16], tmem [16];
  int          vwp = 0, vrp, twp = 0, trp;
  logic        force_vfill = 0;
  logic        vid_rd, txt_rd, dv;
  logic [15:0] dat;
  logic        vid_empty, txt_empty, vid_fill, txt_fill;

  assign vid_empty = vrp == vwp;
  assign txt_empty = trp == twp;
  assign vid_fill  = force_vfill || ((vwp - vrp) >= int'(vid_dw));
  assign txt_fill  = (twp - trp) >= int'(txt_dw);

  oport_ser u_oport_ser (
    .clk_i(clk), .rst_ni(rst_n), .mode16_i(mode16), .arb_i(arb),
    .txt_anc_i(txt_anc), .blank_i(blank), .field_i(field),
    .anc_did_i(8'h41), .anc_blk_i(8'h07), .vid_dw_i(vid_dw), .txt_dw_i(txt_dw),
    .vid_data_i(vmem[vrp[3:0]]), .vid_empty_i(vid_empty), .vid_fill_i(vid_fill),
    .vid_rd_o(vid_rd), .txt_data_i(tmem[trp[3:0]]), .txt_empty_i(txt_empty),
    .txt_fill_i(txt_fill), .txt_rd_o(txt_rd), .dat_o(dat), .dv_o(dv)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin vrp <= 0; trp <= 0; end
    else begin
      if (vid_rd) vrp <= vrp + 1;
      if (txt_rd) trp <= trp + 1;
    end

  int checks = 0, errors = 0;
  logic [7:0] cap [256], expb [256];
  int ncap = 0, nexp = 0;
  logic idle_bad = 0;

  always @(negedge clk)
    if (rst_n) begin
      if (dv) begin
        cap[ncap[7:0]] = dat[7:0]; ncap++;
        if (mode16) begin cap[ncap[7:0]] = dat[15:8]; ncap++; end
      end else if (dat != 16'h0) idle_bad = 1;
      if (!mode16 && dat[15:8] != 8'h0) idle_bad = 1;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [7:0] bclip(input logic [7:0] b);
    return b == 8'h00 ? 8'h01 : (b == 8'hFF ? 8'hFE : b);
  endfunction

  task automatic push(input logic [7:0] b);
    expb[nexp[7:0]] = b; nexp++;
  endtask

  task automatic push_code(input logic f, input logic v, input logic h);
    push(8'hFF); push(8'h00); push(8'h00);
    push({1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h});
  endtask

  task automatic push_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) push(bclip(w[8*k +: 8]));
  endtask

  function automatic logic [31:0] vword(input int s, input int i);
    return {8'hFF, 8'(s * 7 + i), 8'h00, 8'(8'h40 + i)};
  endfunction
  function automatic logic [31:0] tword(input int s, input int i);
    return {8'(8'hA0 + i), 8'h00, 8'(s), 8'hFF};
  endfunction

  task automatic exp_vid(input int s, input logic f);
    push_code(f, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) push_word(vword(s, i));
    push_code(f, 1'b0, 1'b1);
  endtask

  task automatic exp_txt(input int s, input logic f, input logic anc);
    if (anc) begin
      push(8'h00); push(8'hFF); push(8'hFF); push(8'h41); push(8'h07); push(8'd2);
    end else push_code(f, 1'b1, 1'b0);
    for (int i = 0; i < 2; i++) push_word(tword(s, i));
    if (!anc) push_code(f, 1'b1, 1'b1);
  endtask

  task automatic load_vid(input int s, input int from, input int to);
    for (int i = from; i < to; i++) begin vmem[i] = vword(s, i); vwp = i + 1; end
  endtask
  task automatic load_txt(input int s);
    for (int i = 0; i < 2; i++) begin tmem[i] = tword(s, i); twp = i + 1; end
  endtask

  task automatic start_reset();
    @(negedge clk);
    rst_n = 0; vwp = 0; twp = 0; ncap = 0; nexp = 0; idle_bad = 0; force_vfill = 0;
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    bit ok = (ncap == nexp);
    int bad = -1;
    for (int i = 0; i < nexp && i < ncap; i++)
      if (ok && cap[i] != expb[i]) begin ok = 0; bad = i; end
    if (bad >= 0) chk(0, req, {24'h0, cap[bad]}, {24'h0, expb[bad]});
    else chk(ok, req, 32'(ncap), 32'(nexp));
    chk(!idle_bad, "R6 idle filler", {31'h0, idle_bad}, 32'h0);
  endtask

  bit done = 0;

  initial begin
    // R1: reset state with both sources ready
    load_vid(0, 0, 3); load_txt(0);
    repeat (3) @(negedge clk);
    chk(!dv && dat == 0 && !vid_rd && !txt_rd, "R1 reset outputs",
        {dat, 13'h0, dv, vid_rd, txt_rd}, 32'h0);

    // sweep: R2 R3 R4 R5 R7 R8 with policy, blanking, width, framing
    for (int c = 0; c < 32; c++) begin
      start_reset();
      arb = c[1:0]; blank = c[2]; mode16 = c[3]; txt_anc = c[4]; field = c[2] ^ c[3];
      load_vid(c, 0, 3); load_txt(c);
      if (arb == 2'b10) begin exp_txt(c, field, txt_anc); exp_vid(c, field); end
      else begin
        exp_vid(c, field);
        if (arb == 2'b00 || (arb == 2'b01 && blank)) exp_txt(c, field, txt_anc);
      end
      rst_n = 1;
      repeat (80) @(negedge clk);
      compare($sformatf("R2 R3 R4 R5 R7 R8 stream case %0d", c));
    end

    // R6 R10: stall on empty FIFO mid-packet, 16-bit
    start_reset();
    arb = 2'b11; mode16 = 1; field = 1; force_vfill = 1;
    load_vid(40, 0, 1);
    exp_vid(40, 1'b1);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(!dv && dat == 16'h0, "R6 stall filler", {15'h0, dv, dat}, 32'h0);
    chk(!vid_rd, "R10 no pop when empty", {31'h0, vid_rd}, 32'h0);
    load_vid(40, 1, 3);
    force_vfill = 0;
    repeat (40) @(negedge clk);
    compare("R6 R10 stalled packet resumes");

    // R9: late text and field change during a video packet, text priority
    start_reset();
    arb = 2'b10; mode16 = 0; txt_anc = 0; field = 0; blank = 1;
    load_vid(50, 0, 3);
    exp_vid(50, 1'b0); exp_txt(50, 1'b1, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    load_txt(50); field = 1;
    repeat (80) @(negedge clk);
    compare("R9 no preemption, F latched per packet");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule